// File: doc/BRIEF.md
# DE-Only Panel Raster Timing Generator

This block produces the raster timing for a flat panel that takes its timing from a data-enable strobe alone. The panel has no horizontal or vertical sync inputs in this mode. Two counters run on the pixel clock. One counts pixel positions within a line and the other counts lines within a frame. Each line starts with its active pixels and ends with horizontal blanking. Each frame starts with its active lines and ends with vertical blanking. By default the active area is 1366 by 768. At the typical clock of about 77.8 MHz, the typical blanking gives a frame rate of about 60 Hz.

The horizontal and vertical blanking lengths come in on input ports. The legal ranges are 30 to 681 clocks for horizontal blanking, which gives a line period of 1396 to 2047 clocks, and 8 to 255 lines for vertical blanking, which gives a frame period of 776 to 1023 lines. A value outside its range is clamped to the nearer limit, and a sticky error flag is raised. The blanking values are captured only at a frame boundary, so every line in a frame has the same length.

The DE strobe, the column index, the line index and the gated 18-bit colour bus all leave the block from registers. They are therefore stable around the falling clock edge on which the panel samples them. While DE is low the colour bus is held at zero.

Top module: `de_raster_gen`

## Requirements
- R1: While rst_ni is low, and up to the first rising clock edge after it is released, de_o, h_idx_o, v_idx_o, rgb_o and cfg_err_o are all zero.
- R2: h_idx_o counts up by one on each clock, from 0 to H_ACTIVE+HB-1, and then returns to 0. HB is the horizontal blanking length in force for the current frame.
- R3: v_idx_o advances by one each time h_idx_o wraps to 0. It counts from 0 to V_ACTIVE+VB-1 and then returns to 0. VB is the vertical blanking length in force for the current frame.
- R4: The outputs are registered with one cycle of latency. de_o is 1 exactly when h_idx_o < H_ACTIVE and v_idx_o < V_ACTIVE.
- R5: While de_o is 1, rgb_o equals the value that rgb_i had at the same edge, unchanged. Red is bits [17:12], green is bits [11:6] and blue is bits [5:0], each with its MSB at the top of the field.
- R6: While de_o is 0, rgb_o is all zeros, whatever the value of rgb_i.
- R7: A blanking input below its minimum is applied as the minimum. A blanking input above its maximum is applied as the maximum. The limits are 30 and 681 for horizontal blanking and 8 and 255 for vertical blanking.
- R8: cfg_err_o rises one cycle after either blanking input is out of range at a clock edge. It then stays at 1 until reset.
- R9: The blanking inputs are sampled only at the last clock of a frame. Changes at any other time have no effect on the line length or the frame length.
- R10: The first frame after reset uses the blanking defaults H_BLANK_RST (240) and V_BLANK_RST (40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_blank_i | input | BLANK_W | Requested horizontal blanking, in clocks |
| v_blank_i | input | BLANK_W | Requested vertical blanking, in lines |
| rgb_i | input | 18 | Pixel colour: red [17:12], green [11:6], blue [5:0] |
| de_o | output | 1 | Data enable strobe |
| h_idx_o | output | HW | Pixel position within the line |
| v_idx_o | output | VW | Line position within the frame |
| rgb_o | output | 18 | Gated pixel colour |
| cfg_err_o | output | 1 | Sticky flag for an out-of-range blanking value |

## Verification
The bench runs the block with a small active area so that many whole frames fit in the run, and it tracks the expected position, DE and colour on every cycle. Directed frames at the minimum and maximum blanking check the wrap points of both counters. Frames with the blanking inputs changed on every cycle inside a frame show whether anything is sampled before the frame boundary. Values below and above the legal range show whether clamping goes to the correct limit, and whether the error flag rises and then holds. In the random frames, fresh random colour on every cycle shows whether gating and pass-through follow DE exactly, including on the first and last active pixel of a line.

// File: rtl/de_raster_pkg.sv
package de_raster_pkg;
  localparam int COLOR_W = 6;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
  } rgb18_t;

  localparam int RGB_W = $bits(rgb18_t);
endpackage

// File: rtl/blank_clamp.sv
module blank_clamp #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 10,
  parameter int MIN_V = 30,
  parameter int MAX_V = 681
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o,
  output logic             bad_o
);
  localparam logic [IN_W-1:0] MIN_L = IN_W'(MIN_V);
  localparam logic [IN_W-1:0] MAX_L = IN_W'(MAX_V);

  logic lo, hi;

  always_comb begin
    lo = val_i < MIN_L;
    hi = val_i > MAX_L;
    bad_o = lo | hi;
    if (lo)      val_o = OUT_W'(MIN_V);
    else if (hi) val_o = OUT_W'(MAX_V);
    else         val_o = OUT_W'(val_i);
  end

  always_comb begin
    if (!$isunknown(val_i)) begin
      AST_CLAMP_RANGE: assert (int'(val_o) >= MIN_V && int'(val_o) <= MAX_V); // R7
    end
  end
endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = cnt_q == last_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (en_i)   cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/de_raster_gen.sv
module de_raster_gen
  import de_raster_pkg::*;
#(
  parameter int H_ACTIVE    = 1366,
  parameter int V_ACTIVE    = 768,
  parameter int H_BLANK_MIN = 30,
  parameter int H_BLANK_MAX = 681,
  parameter int V_BLANK_MIN = 8,
  parameter int V_BLANK_MAX = 255,
  parameter int H_BLANK_RST = 240,
  parameter int V_BLANK_RST = 40,
  parameter int BLANK_W     = 12,
  localparam int HW  = $clog2(H_ACTIVE + H_BLANK_MAX),
  localparam int VW  = $clog2(V_ACTIVE + V_BLANK_MAX),
  localparam int HBW = $clog2(H_BLANK_MAX + 1),
  localparam int VBW = $clog2(V_BLANK_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BLANK_W-1:0] h_blank_i,
  input  logic [BLANK_W-1:0] v_blank_i,
  input  logic [RGB_W-1:0]   rgb_i,
  output logic               de_o,
  output logic [HW-1:0]      h_idx_o,
  output logic [VW-1:0]      v_idx_o,
  output logic [RGB_W-1:0]   rgb_o,
  output logic               cfg_err_o
);
  localparam logic [HW-1:0] H_ACT_L = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_ACT_L = VW'(V_ACTIVE);

  logic [HBW-1:0] h_cl, hb_q;
  logic [VBW-1:0] v_cl, vb_q;
  logic           h_bad, v_bad;
  logic [HW-1:0]  h_last, h_cnt;
  logic [VW-1:0]  v_last, v_cnt;
  logic           h_wrap, v_wrap, frame_end, active;
  rgb18_t         pix_in, pix_q;

  blank_clamp #(.IN_W(BLANK_W), .OUT_W(HBW), .MIN_V(H_BLANK_MIN), .MAX_V(H_BLANK_MAX))
    i_h_clamp (.val_i(h_blank_i), .val_o(h_cl), .bad_o(h_bad));

  blank_clamp #(.IN_W(BLANK_W), .OUT_W(VBW), .MIN_V(V_BLANK_MIN), .MAX_V(V_BLANK_MAX))
    i_v_clamp (.val_i(v_blank_i), .val_o(v_cl), .bad_o(v_bad));

  assign h_last    = H_ACT_L + HW'(hb_q) - 1'b1;
  assign v_last    = V_ACT_L + VW'(vb_q) - 1'b1;
  assign frame_end = h_wrap & v_wrap;

  raster_counter #(.W(HW)) i_h_cnt (
    .clk_i, .rst_ni, .en_i(1'b1), .last_i(h_last), .cnt_o(h_cnt), .wrap_o(h_wrap));

  raster_counter #(.W(VW)) i_v_cnt (
    .clk_i, .rst_ni, .en_i(h_wrap), .last_i(v_last), .cnt_o(v_cnt), .wrap_o(v_wrap));

  // blanking captured only on the last clock of a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q <= HBW'(H_BLANK_RST);
      vb_q <= VBW'(V_BLANK_RST);
    end else if (frame_end) begin
      hb_q <= h_cl;
      vb_q <= v_cl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_err_o <= 1'b0;
    else         cfg_err_o <= cfg_err_o | h_bad | v_bad;
  end

  assign active = (h_cnt < H_ACT_L) && (v_cnt < V_ACT_L);
  assign pix_in = rgb18_t'(rgb_i);

  // output stage registered so DE is settled well before the falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o    <= 1'b0;
      h_idx_o <= '0;
      v_idx_o <= '0;
      pix_q   <= '0;
    end else begin
      de_o    <= active;
      h_idx_o <= h_cnt;
      v_idx_o <= v_cnt;
      pix_q   <= active ? pix_in : '0;
    end
  end

  assign rgb_o = pix_q;

  AST_DE_AREA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (h_idx_o < H_ACT_L && v_idx_o < V_ACT_L)); // R4
  AST_DE_ZERO_RGB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> rgb_o == '0); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R8
  AST_BLANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> ($stable(hb_q) && $stable(vb_q))); // R9
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_idx_o != '0 && $past(h_idx_o) != h_idx_o) |-> $stable(v_idx_o)); // R3
endmodule

// File: tb/test_de_raster_gen.sv
module test_de_raster_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 16, VA = 6;
  localparam int HMIN = 3, HMAX = 20, VMIN = 2, VMAX = 9;
  localparam int HRST = 5, VRST = 3, BW = 8;
  localparam int HW = $clog2(HA + HMAX);
  localparam int VW = $clog2(VA + VMAX);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [BW-1:0] h_blank_i = BW'(HMIN);
  logic [BW-1:0] v_blank_i = BW'(VMIN);
  logic [17:0]   rgb_i = '0;
  logic          de_o, cfg_err_o;
  logic [HW-1:0] h_idx_o;
  logic [VW-1:0] v_idx_o;
  logic [17:0]   rgb_o;

  de_raster_gen #(
    .H_ACTIVE(HA), .V_ACTIVE(VA), .H_BLANK_MIN(HMIN), .H_BLANK_MAX(HMAX),
    .V_BLANK_MIN(VMIN), .V_BLANK_MAX(VMAX), .H_BLANK_RST(HRST), .V_BLANK_RST(VRST),
    .BLANK_W(BW)
  ) i_de_raster_gen (
    .clk_i, .rst_ni, .h_blank_i, .v_blank_i, .rgb_i,
    .de_o, .h_idx_o, .v_idx_o, .rgb_o, .cfg_err_o);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R2";
  int mh, mv, mhb, mvb, frames;
  bit merr;
  int e_h, e_v, e_rgb;
  bit e_de;
  bit hop = 0; // random blanking change every cycle

  function automatic int clampv(int x, int lo, int hi);
    return x < lo ? lo : (x > hi ? hi : x);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mh = 0; mv = 0; mhb = HRST; mvb = VRST; merr = 0;
  endtask

  task automatic step();
    bit act;
    @(posedge clk_i);
    act   = (mh < HA) && (mv < VA);
    e_de  = act;
    e_h   = mh;
    e_v   = mv;
    e_rgb = act ? int'(rgb_i) : 0;
    if (int'(h_blank_i) < HMIN || int'(h_blank_i) > HMAX ||
        int'(v_blank_i) < VMIN || int'(v_blank_i) > VMAX) merr = 1;
    if (mh == HA + mhb - 1) begin
      mh = 0;
      if (mv == VA + mvb - 1) begin
        mv = 0;
        mhb = clampv(int'(h_blank_i), HMIN, HMAX);
        mvb = clampv(int'(v_blank_i), VMIN, VMAX);
        frames++;
      end else mv++;
    end else mh++;
    @(negedge clk_i);
    check(int'(h_idx_o) == e_h, tag, "h_idx", int'(h_idx_o), e_h);
    check(int'(v_idx_o) == e_v, tag, "v_idx", int'(v_idx_o), e_v);
    check(de_o == e_de, "R4", "de", int'(de_o), int'(e_de));
    if (e_de) check(int'(rgb_o) == e_rgb, "R5", "rgb pass", int'(rgb_o), e_rgb);
    else      check(rgb_o == '0, "R6", "rgb gated", int'(rgb_o), 0);
    check(cfg_err_o == merr, "R8", "cfg_err", int'(cfg_err_o), int'(merr));
    rgb_i = 18'($urandom);
    if (hop) begin
      h_blank_i = BW'(HMIN + $urandom_range(HMAX - HMIN));
      v_blank_i = BW'(VMIN + $urandom_range(VMAX - VMIN));
    end
  endtask

  task automatic run_frames(int n);
    int target;
    target = frames + n;
    while (frames < target) step();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(de_o == 0 && rgb_o == '0, "R1", "de/rgb in reset", int'(rgb_o), 0);
    check(h_idx_o == '0 && v_idx_o == '0, "R1", "idx in reset", int'(h_idx_o), 0);
    check(cfg_err_o == 0, "R1", "err in reset", int'(cfg_err_o), 0);
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    frames = 0;
    do_reset();
    tag = "R10"; h_blank_i = BW'(HMAX); v_blank_i = BW'(VMAX);
    run_frames(1);
    tag = "R2"; run_frames(1);
    h_blank_i = BW'(HMIN); v_blank_i = BW'(VMIN);
    tag = "R3"; run_frames(2);
    check(cfg_err_o == 0, "R8", "no err in range", int'(cfg_err_o), 0);
    tag = "R9"; hop = 1; run_frames(3); hop = 0;
    tag = "R7"; h_blank_i = 0; v_blank_i = BW'(VMAX + 7);
    run_frames(2);
    h_blank_i = BW'(HMAX + 30); v_blank_i = 0;
    run_frames(2);
    h_blank_i = BW'(HMIN + 2); v_blank_i = BW'(VMIN + 1);
    tag = "R8"; run_frames(1);
    check(cfg_err_o == 1, "R8", "err sticky", int'(cfg_err_o), 1);
    do_reset();
    tag = "R10"; run_frames(1);
    for (int f = 0; f < 15; f++) begin
      tag = "R3";
      h_blank_i = BW'($urandom_range(HMAX + 6));
      v_blank_i = BW'($urandom_range(VMAX + 4));
      run_frames(1);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule